// File: doc/BRIEF.md
# Pipeline Hazard and Forwarding Control

This block is the hazard controller for an in-order five-stage integer pipeline with fetch, decode, execute, memory and writeback stages. It is purely combinational. It compares the register numbers held in the pipeline registers and drives four things: the operand bypass selects for the execute stage, a bypass select for store data in the memory stage, a front-end hold with a bubble insert for load-use hazards, and a flush of the younger stages when a branch resolves taken in the memory stage.

The pipeline writes its registers in writeback, after the stage in which operands are read. A consumer can therefore see a stale value, and that read-after-write case is the only hazard the block detects. Write-after-read and write-after-write cannot occur in this ordering, so no logic covers them. The block adds a path that sends a loaded value straight into the store data of the store that follows the load, so a load-then-store copy runs without a stall. It also decides what happens in a cycle that requests a stall and a flush at the same time.

Top module: `hz_ctrl`

## Requirements
- R1: `fwd_a_o`/`fwd_b_o` select 2'b10 (memory-stage result) for the execute source `ex_rs_i`/`ex_rt_i` when the memory-stage instruction writes a register, is not a load, and its destination equals that source.
- R2: When R1 does not apply and the writeback-stage instruction writes a register whose number equals the source, the select is 2'b01 (writeback value). Otherwise it is 2'b00 (register file). The value 2'b11 never appears.
- R3: When both the memory and the writeback stage match a source, the memory-stage result (2'b10) wins.
- R4: Register 0 never produces an operand bypass, a store-data bypass or a stall.
- R5: A load in execute whose destination matches the decode-stage `id_rs_i`, or matches `id_rt_i` of an instruction that is not a store, raises `fe_hold_o` (hold PC and the fetch/decode register) and `bubble_o` (clear execute control) together.
- R6: A load in execute followed in decode by a store whose only match is its data register `id_rt_i` causes no hold and no bubble.
- R7: A store in decode whose base register `id_rs_i` matches the destination of a load in execute stalls as in R5.
- R8: `st_fwd_o` is 1 exactly when the memory-stage instruction is a store, the writeback stage writes a nonzero register, and that register equals the store's data register `mem_rt_i`.
- R9: When `mem_br_taken_i` is 1, `flush_o` is 1, and `fe_hold_o` and `bubble_o` are 0 whatever the load-use check finds, so the PC takes the branch target.
- R10: A load that has already reached the memory stage, or any register write other than a load in execute, never stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs_i | input | AW | decode-stage first source (store base) |
| id_rt_i | input | AW | decode-stage second source (store data) |
| id_is_store_i | input | 1 | decode-stage instruction is a store |
| ex_rs_i | input | AW | execute-stage first source |
| ex_rt_i | input | AW | execute-stage second source |
| ex_rd_i | input | AW | execute-stage destination |
| ex_reg_wr_i | input | 1 | execute-stage instruction writes a register |
| ex_mem_rd_i | input | 1 | execute-stage instruction is a load |
| mem_rd_i | input | AW | memory-stage destination |
| mem_rt_i | input | AW | memory-stage store data register |
| mem_reg_wr_i | input | 1 | memory-stage instruction writes a register |
| mem_mem_rd_i | input | 1 | memory-stage instruction is a load |
| mem_is_store_i | input | 1 | memory-stage instruction is a store |
| mem_br_taken_i | input | 1 | branch in memory stage resolved taken |
| wb_rd_i | input | AW | writeback-stage destination |
| wb_reg_wr_i | input | 1 | writeback-stage instruction writes a register |
| fwd_a_o | output | 2 | bypass select for execute first operand |
| fwd_b_o | output | 2 | bypass select for execute second operand |
| st_fwd_o | output | 1 | store data taken from writeback value |
| fe_hold_o | output | 1 | hold PC and fetch/decode register |
| bubble_o | output | 1 | clear control bits into execute |
| flush_o | output | 1 | flush the younger stages, load branch target |

## Verification
Random specifiers drawn from registers 0 to 3 make memory-stage and writeback-stage matches frequent. That separates the bypass priority from plain single matches and exercises register 0 on every class of output. Directed load-then-store pairs, one matching on the data register and one on the base, tell the no-stall store path from the ordinary load-use stall. A taken branch applied together with a load-use match shows whether the flush overrides the hold and bubble. A load that is in memory rather than execute shows that only an adjacent load stalls.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit #(
  parameter int AW   = 5,
  parameter int NSRC = 2
) (
  input  logic [NSRC-1:0][AW-1:0] src_i,
  input  logic [AW-1:0]           mem_rd_i,
  input  logic                    mem_wr_i,
  input  logic                    mem_ld_i,
  input  logic [AW-1:0]           wb_rd_i,
  input  logic                    wb_wr_i,
  output logic [NSRC-1:0][1:0]    sel_o
);
  import hz_pkg::*;
  logic mem_ok, wb_ok;
  // load data is not ready in memory stage; never bypass it from there
  assign mem_ok = mem_wr_i && !mem_ld_i && (mem_rd_i != '0);
  assign wb_ok  = wb_wr_i && (wb_rd_i != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    always_comb begin
      if (mem_ok && (mem_rd_i == src_i[g]))     sel_o[g] = FWD_MEM;
      else if (wb_ok && (wb_rd_i == src_i[g]))  sel_o[g] = FWD_WB;
      else                                      sel_o[g] = FWD_RF;
    end
  end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_is_store_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_ld_i,
  output logic          stall_o
);
  logic hit_rs, hit_rt;
  assign hit_rs = (ex_rd_i == id_rs_i);
  // store data gets the loaded value via the memory-stage bypass
  assign hit_rt = (ex_rd_i == id_rt_i) && !id_is_store_i;
  assign stall_o = ex_ld_i && (ex_rd_i != '0) && (hit_rs || hit_rt);
endmodule

// File: rtl/hz_st_fwd.sv
module hz_st_fwd #(
  parameter int AW = 5
) (
  input  logic          mem_is_store_i,
  input  logic [AW-1:0] mem_rt_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_wr_i,
  output logic          sel_o
);
  assign sel_o = mem_is_store_i && wb_wr_i && (wb_rd_i != '0) && (wb_rd_i == mem_rt_i);
endmodule

// File: rtl/hz_ctrl.sv
module hz_ctrl #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs_i,
  input  logic [AW-1:0] id_rt_i,
  input  logic          id_is_store_i,
  input  logic [AW-1:0] ex_rs_i,
  input  logic [AW-1:0] ex_rt_i,
  input  logic [AW-1:0] ex_rd_i,
  input  logic          ex_reg_wr_i,
  input  logic          ex_mem_rd_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic [AW-1:0] mem_rt_i,
  input  logic          mem_reg_wr_i,
  input  logic          mem_mem_rd_i,
  input  logic          mem_is_store_i,
  input  logic          mem_br_taken_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_reg_wr_i,
  output logic [1:0]    fwd_a_o,
  output logic [1:0]    fwd_b_o,
  output logic          st_fwd_o,
  output logic          fe_hold_o,
  output logic          bubble_o,
  output logic          flush_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0][AW-1:0] ex_src;
  logic [NSRC-1:0][1:0]    ex_sel;
  logic                    lu_stall;

  assign ex_src[0] = ex_rs_i;
  assign ex_src[1] = ex_rt_i;

  hz_fwd_unit #(.AW(AW), .NSRC(NSRC)) u_fwd (
    .src_i    (ex_src),
    .mem_rd_i (mem_rd_i),
    .mem_wr_i (mem_reg_wr_i),
    .mem_ld_i (mem_mem_rd_i),
    .wb_rd_i  (wb_rd_i),
    .wb_wr_i  (wb_reg_wr_i),
    .sel_o    (ex_sel)
  );

  assign fwd_a_o = ex_sel[0];
  assign fwd_b_o = ex_sel[1];

  hz_load_use #(.AW(AW)) u_lu (
    .id_rs_i       (id_rs_i),
    .id_rt_i       (id_rt_i),
    .id_is_store_i (id_is_store_i),
    .ex_rd_i       (ex_rd_i),
    .ex_ld_i       (ex_mem_rd_i && ex_reg_wr_i),
    .stall_o       (lu_stall)
  );

  hz_st_fwd #(.AW(AW)) u_stf (
    .mem_is_store_i (mem_is_store_i),
    .mem_rt_i       (mem_rt_i),
    .wb_rd_i        (wb_rd_i),
    .wb_wr_i        (wb_reg_wr_i),
    .sel_o          (st_fwd_o)
  );

  // taken branch wins: stalled instruction is flushed, not held
  assign flush_o   = mem_br_taken_i;
  assign fe_hold_o = lu_stall && !mem_br_taken_i;
  assign bubble_o  = lu_stall && !mem_br_taken_i;
endmodule

// File: rtl/hz_ctrl_chk.sv
module hz_ctrl_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] id_rs_i,
  input logic [AW-1:0] id_rt_i,
  input logic          id_is_store_i,
  input logic [AW-1:0] ex_rs_i,
  input logic [AW-1:0] ex_rt_i,
  input logic [AW-1:0] ex_rd_i,
  input logic          ex_reg_wr_i,
  input logic          ex_mem_rd_i,
  input logic [AW-1:0] mem_rd_i,
  input logic [AW-1:0] mem_rt_i,
  input logic          mem_reg_wr_i,
  input logic          mem_mem_rd_i,
  input logic          mem_is_store_i,
  input logic          mem_br_taken_i,
  input logic [AW-1:0] wb_rd_i,
  input logic          wb_reg_wr_i,
  input logic [1:0]    fwd_a_o,
  input logic [1:0]    fwd_b_o,
  input logic          st_fwd_o,
  input logic          fe_hold_o,
  input logic          bubble_o,
  input logic          flush_o
);
  always_comb begin
    p_mem_sel_src_r1: assert (fwd_a_o != 2'b10 || (mem_reg_wr_i && !mem_mem_rd_i && mem_rd_i == ex_rs_i));
    p_no_code3_r2:    assert (fwd_a_o != 2'b11 && fwd_b_o != 2'b11);
    p_wb_sel_src_r2:  assert (fwd_b_o != 2'b01 || (wb_reg_wr_i && wb_rd_i == ex_rt_i));
    p_mem_first_r3:   assert (!(mem_reg_wr_i && !mem_mem_rd_i && mem_rd_i == ex_rs_i && mem_rd_i != '0)
                              || fwd_a_o == 2'b10);
    p_zero_src_r4:    assert (ex_rs_i != '0 || fwd_a_o == 2'b00);
    p_zero_hold_r4:   assert (ex_rd_i != '0 || !fe_hold_o);
    p_hold_bub_r5:    assert (fe_hold_o == bubble_o);
    p_hold_load_r10:  assert (!fe_hold_o || (ex_mem_rd_i && ex_reg_wr_i));
    p_stfwd_st_r8:    assert (!st_fwd_o || (mem_is_store_i && wb_reg_wr_i && wb_rd_i == mem_rt_i));
    p_flush_wins_r9:  assert (!flush_o || (!fe_hold_o && !bubble_o));
    p_flush_br_r9:    assert (flush_o == mem_br_taken_i);
  end
endmodule

bind hz_ctrl hz_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/hz_ctrl_bench.sv
module hz_ctrl_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [AW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_rt, wb_rd;
  logic id_st, ex_wr, ex_ld, mem_wr, mem_ld, mem_st, br, wb_wr;
  logic [1:0] fwd_a, fwd_b;
  logic st_fwd, hold, bub, flush;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  hz_ctrl #(.AW(AW)) u_hz_ctrl (
    .id_rs_i(id_rs), .id_rt_i(id_rt), .id_is_store_i(id_st),
    .ex_rs_i(ex_rs), .ex_rt_i(ex_rt), .ex_rd_i(ex_rd),
    .ex_reg_wr_i(ex_wr), .ex_mem_rd_i(ex_ld),
    .mem_rd_i(mem_rd), .mem_rt_i(mem_rt), .mem_reg_wr_i(mem_wr),
    .mem_mem_rd_i(mem_ld), .mem_is_store_i(mem_st), .mem_br_taken_i(br),
    .wb_rd_i(wb_rd), .wb_reg_wr_i(wb_wr),
    .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .st_fwd_o(st_fwd),
    .fe_hold_o(hold), .bubble_o(bub), .flush_o(flush)
  );

  function automatic logic [1:0] ref_sel(input int src);
    if (mem_wr && !mem_ld && mem_rd != 0 && int'(mem_rd) == src) return 2'b10;
    if (wb_wr && wb_rd != 0 && int'(wb_rd) == src) return 2'b01;
    return 2'b00;
  endfunction

  function automatic bit ref_stall();
    bit hit = 0;
    if (ex_ld && ex_wr && ex_rd != 0) begin
      if (ex_rd == id_rs) hit = 1;
      if (ex_rd == id_rt && !id_st) hit = 1;
    end
    return hit && !br;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R1 R2 R3 R4 fwd_a", fwd_a, ref_sel(ex_rs));
    chk("R1 R2 R3 R4 fwd_b", fwd_b, ref_sel(ex_rt));
    chk("R8 st_fwd", st_fwd, mem_st && wb_wr && wb_rd != 0 && wb_rd == mem_rt);
    chk("R5 R7 R9 R10 hold", hold, ref_stall());
    chk("R5 R9 bubble", bub, ref_stall());
    chk("R9 flush", flush, br);
  endtask

  task automatic clear();
    {id_rs, id_rt, ex_rs, ex_rt, ex_rd, mem_rd, mem_rt, wb_rd} = '0;
    {id_st, ex_wr, ex_ld, mem_wr, mem_ld, mem_st, br, wb_wr} = '0;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    clear();
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    // reset / idle state
    chk("R10 idle fwd_a", fwd_a, 0);
    chk("R10 idle hold", hold, 0);
    chk("R9 idle flush", flush, 0);

    // R3: both stages match, memory stage wins
    @(negedge clk); clear();
    ex_rs = 3; mem_rd = 3; mem_wr = 1; wb_rd = 3; wb_wr = 1; #1;
    chk("R3 mem over wb", fwd_a, 2);
    // R1: load in memory stage is not bypassed from there
    mem_ld = 1; #1;
    chk("R1 load in mem not bypassed", fwd_a, 1);
    // R4: register 0
    @(negedge clk); clear();
    ex_rt = 0; mem_wr = 1; wb_wr = 1; #1;
    chk("R4 zero src", fwd_b, 0);
    ex_ld = 1; ex_wr = 1; ex_rd = 0; id_rs = 0; #1;
    chk("R4 zero stall", hold, 0);
    mem_st = 1; mem_rt = 0; wb_rd = 0; #1;
    chk("R4 zero store fwd", st_fwd, 0);

    // R6: load then store of loaded register as data
    @(negedge clk); clear();
    ex_ld = 1; ex_wr = 1; ex_rd = 7; id_st = 1; id_rt = 7; id_rs = 9; #1;
    chk("R6 store data no stall", hold, 0);
    chk("R6 store data no bubble", bub, 0);
    // R7: same store using the loaded register as base
    id_rs = 7; id_rt = 2; #1;
    chk("R7 store base stalls", hold, 1);
    chk("R5 R7 bubble", bub, 1);
    // R5: ALU consumer on rt
    id_st = 0; id_rs = 1; id_rt = 7; #1;
    chk("R5 alu rt stall", hold, 1);
    // R9: taken branch overrides stall
    br = 1; #1;
    chk("R9 flush", flush, 1);
    chk("R9 hold cleared", hold, 0);
    chk("R9 bubble cleared", bub, 0);
    // R10: load one stage later does not stall
    @(negedge clk); clear();
    mem_ld = 1; mem_wr = 1; mem_rd = 7; id_rs = 7; id_rt = 7; #1;
    chk("R10 load in mem no stall", hold, 0);
    ex_wr = 1; ex_rd = 7; #1;
    chk("R10 alu in ex no stall", hold, 0);
    // R8: store in memory, load in writeback
    @(negedge clk); clear();
    mem_st = 1; mem_rt = 6; wb_wr = 1; wb_rd = 6; #1;
    chk("R8 store data fwd", st_fwd, 1);
    wb_rd = 5; #1;
    chk("R8 no match", st_fwd, 0);

    // random patterns over a small register range, compared every clock
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      id_rs = AW'($urandom_range(0, 3)); id_rt = AW'($urandom_range(0, 3));
      ex_rs = AW'($urandom_range(0, 3)); ex_rt = AW'($urandom_range(0, 3));
      ex_rd = AW'($urandom_range(0, 3)); mem_rd = AW'($urandom_range(0, 3));
      mem_rt = AW'($urandom_range(0, 3)); wb_rd = AW'($urandom_range(0, 3));
      {id_st, ex_wr, ex_ld, mem_wr, mem_ld, mem_st, wb_wr} = 7'($urandom);
      br = ($urandom_range(0, 7) == 0);
      #1;
      compare_all();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule